// File: doc/BRIEF.md
# Triangle Tile Binning Unit

This block sits between the geometry stage and a tiled rasterizer. Each incoming screen-space triangle is reduced to the rectangle of screen tiles its vertex bounding box touches. The triangle's index is then appended to the on-chip list of every tile in that rectangle, one tile per clock. A triangle that spans several tiles therefore appears in several lists. Binning and rasterization are two separate partitions: the lists are the only thing passed between them.

When the producer signals the end of the frame and the last triangle has been binned, the unit raises a done flag and opens its readout stream. The rasterizer then drains the lists tile by tile in row-major order. Each tile is presented as a header beat carrying the tile number, then its triangle indices in arrival order, then an end marker. When the last tile's end marker is accepted, all lists and the overflow flag are cleared and a new frame can be binned. Default geometry: a 64x64 pixel screen, 16x16 pixel tiles (a 4x4 grid, tile number = row*4 + column), four entries per tile list and 6-bit triangle indices.

Top module: `tile_binner`

## Requirements
- R1: After reset, in_ready is 1 and bin_done, out_valid and overflow are 0.
- R2: A triangle's tile range on each axis runs from the minimum to the maximum of its three vertex coordinates, each shifted right by 4 and clamped to 3; the tile number is row*4 + column.
- R3: An accepted triangle is written to every tile of its range, one tile per cycle, and in_ready stays low for exactly as many cycles as the range holds tiles.
- R4: frame_end is taken in a cycle with in_ready high. If a triangle is accepted in the same cycle it is the frame's last, and bin_done rises in the cycle after its last tile write; with no triangle, bin_done rises in the next cycle. While bin_done is high, in_ready is low.
- R5: out_valid stays low while bin_done is low, so no readout happens during binning.
- R6: Readout visits tiles 0 to 15 in order. Each tile gives a header beat (out_kind 0, out_tile = tile number), then one beat per stored index (out_kind 1, out_idx) in arrival order, then an end beat (out_kind 2). A beat moves on only when out_valid and out_ready are both high.
- R7: While out_valid is high and out_ready is low, out_kind, out_tile and out_idx hold their values.
- R8: A tile list holds 4 indices. An index aimed at a full list is dropped and overflow goes to 1, staying 1 until readout of the frame ends.
- R9: In the cycle after the final end beat is accepted, bin_done and overflow are 0, in_ready is 1 and every list is empty.
- R10: A tile with no entries gives its header beat followed directly by its end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Triangle present on the input |
| in_ready | output | 1 | Unit can take a triangle or frame_end |
| in_idx | input | 6 | Triangle index |
| in_x0 | input | 8 | Vertex 0 X |
| in_y0 | input | 8 | Vertex 0 Y |
| in_x1 | input | 8 | Vertex 1 X |
| in_y1 | input | 8 | Vertex 1 Y |
| in_x2 | input | 8 | Vertex 2 X |
| in_y2 | input | 8 | Vertex 2 Y |
| frame_end | input | 1 | Frame closes after this cycle's triangle, if any |
| bin_done | output | 1 | Frame fully binned; readout open |
| overflow | output | 1 | A tile list overflowed this frame |
| out_valid | output | 1 | Readout beat present |
| out_ready | input | 1 | Rasterizer accepts the beat |
| out_kind | output | 2 | 0 header, 1 entry, 2 end of tile |
| out_tile | output | 4 | Tile number of the current beat |
| out_idx | output | 6 | Triangle index on entry beats, else 0 |

## Verification
After an accepted triangle covering N tiles, in_ready returns high N cycles later. For the frame's last triangle, bin_done is due in that same cycle instead. A lone frame_end brings bin_done one cycle after it is taken. The bench counts those cycles on falling edges from the accept edge and checks in_ready, bin_done and out_valid at each of them. Readout beats are due whenever out_valid and out_ready are both high. The monitor sets out_ready in a fixed stall pattern on each falling edge and compares a beat against the scoreboard queue only when the handshake will complete at the next rising edge. It also checks that a stalled beat is unchanged one cycle later. The cleared state is checked in the first cycle after the final end beat.

// File: rtl/tile_binner_pkg.sv
package tile_binner_pkg;
    typedef enum logic [2:0] {
        ST_ACCEPT,
        ST_WALK,
        ST_HDR,
        ST_ENT,
        ST_EOT
    } bin_state_e;

    localparam logic [1:0] KIND_HDR = 2'd0;
    localparam logic [1:0] KIND_ENT = 2'd1;
    localparam logic [1:0] KIND_EOT = 2'd2;
endpackage

// File: rtl/tb_axis_range.sv
module tb_axis_range #(
    parameter int COORD_W   = 8,
    parameter int TILE_LOG2 = 4,
    parameter int GRID_LOG2 = 2
) (
    input  logic [COORD_W-1:0]   c0,
    input  logic [COORD_W-1:0]   c1,
    input  logic [COORD_W-1:0]   c2,
    output logic [GRID_LOG2-1:0] lo,
    output logic [GRID_LOG2-1:0] hi
);
    localparam int SH_W = COORD_W - TILE_LOG2;
    localparam logic [SH_W-1:0] LAST = SH_W'((1 << GRID_LOG2) - 1);

    logic [COORD_W-1:0] mn, mx;
    logic [SH_W-1:0]    mn_t, mx_t;

    always_comb begin
        mn = c0;
        mx = c0;
        if (c1 < mn) mn = c1;
        if (c2 < mn) mn = c2;
        if (c1 > mx) mx = c1;
        if (c2 > mx) mx = c2;
        mn_t = mn[COORD_W-1:TILE_LOG2];
        mx_t = mx[COORD_W-1:TILE_LOG2];
        lo = (mn_t > LAST) ? LAST[GRID_LOG2-1:0] : mn_t[GRID_LOG2-1:0];
        hi = (mx_t > LAST) ? LAST[GRID_LOG2-1:0] : mx_t[GRID_LOG2-1:0];
    end
endmodule

// File: rtl/tb_list_mem.sv
module tb_list_mem #(
    parameter int NT    = 16,
    parameter int DEPTH = 4,
    parameter int IDX_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [$clog2(NT)-1:0]    wr_tile,
    input  logic [IDX_W-1:0]         wr_idx,
    output logic                     wr_full,
    input  logic [$clog2(NT)-1:0]    rd_tile,
    input  logic [$clog2(DEPTH)-1:0] rd_pos,
    output logic [$clog2(DEPTH+1)-1:0] rd_cnt,
    output logic [IDX_W-1:0]         rd_idx
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int POS_W = $clog2(DEPTH);

    logic [NT-1:0][CNT_W-1:0] cnt_arr;
    logic [IDX_W-1:0]         ent [NT][DEPTH];
    logic [CNT_W-1:0]         wr_cnt;

    assign wr_cnt  = cnt_arr[wr_tile];
    assign wr_full = (wr_cnt == CNT_W'(DEPTH));
    assign rd_cnt  = cnt_arr[rd_tile];
    assign rd_idx  = ent[rd_tile][rd_pos];

    for (genvar t = 0; t < NT; t++) begin : g_tile
        logic [CNT_W-1:0] cnt_q, cnt_d;
        always_comb begin
            cnt_d = cnt_q;
            if (clr)
                cnt_d = '0;
            else if (wr_en && wr_tile == t && cnt_q != CNT_W'(DEPTH))
                cnt_d = cnt_q + 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end
        assign cnt_arr[t] = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !wr_full)
            ent[wr_tile][wr_cnt[POS_W-1:0]] <= wr_idx;
    end

    a_r8_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CNT_W'(DEPTH));
    a_r9_lists_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_cnt == '0));
endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tile_binner_pkg::*;
#(
    parameter int COORD_W     = 8,
    parameter int SCREEN_LOG2 = 6,
    parameter int TILE_LOG2   = 4,
    parameter int DEPTH       = 4,
    parameter int IDX_W       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [COORD_W-1:0] in_x0,
    input  logic [COORD_W-1:0] in_y0,
    input  logic [COORD_W-1:0] in_x1,
    input  logic [COORD_W-1:0] in_y1,
    input  logic [COORD_W-1:0] in_x2,
    input  logic [COORD_W-1:0] in_y2,
    input  logic               frame_end,
    output logic               bin_done,
    output logic               overflow,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [1:0]         out_kind,
    output logic [2*(SCREEN_LOG2-TILE_LOG2)-1:0] out_tile,
    output logic [IDX_W-1:0]   out_idx
);
    localparam int GRID_LOG2 = SCREEN_LOG2 - TILE_LOG2;
    localparam int TN_W      = 2 * GRID_LOG2;
    localparam int NT        = 1 << TN_W;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int POS_W     = $clog2(DEPTH);

    typedef struct packed {
        bin_state_e             state;
        logic                   done;
        logic                   ovf;
        logic                   pend;
        logic [GRID_LOG2-1:0]   xlo, xhi, ylo, yhi, cx, cy;
        logic [IDX_W-1:0]       idx;
        logic [TN_W-1:0]        rtile;
        logic [POS_W-1:0]       rpos;
    } bin_regs_t;

    bin_regs_t r_q, r_d;

    logic [GRID_LOG2-1:0] nx_lo, nx_hi, ny_lo, ny_hi;
    logic                 wr_en, wr_full, clr;
    logic [CNT_W-1:0]     rd_cnt;
    logic [IDX_W-1:0]     rd_idx;

    tb_axis_range #(.COORD_W(COORD_W), .TILE_LOG2(TILE_LOG2), .GRID_LOG2(GRID_LOG2))
    u_xr (.c0(in_x0), .c1(in_x1), .c2(in_x2), .lo(nx_lo), .hi(nx_hi));

    tb_axis_range #(.COORD_W(COORD_W), .TILE_LOG2(TILE_LOG2), .GRID_LOG2(GRID_LOG2))
    u_yr (.c0(in_y0), .c1(in_y1), .c2(in_y2), .lo(ny_lo), .hi(ny_hi));

    assign wr_en = (r_q.state == ST_WALK);
    assign clr   = (r_q.state == ST_EOT) && out_ready && (r_q.rtile == TN_W'(NT - 1));

    tb_list_mem #(.NT(NT), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_tile ({r_q.cy, r_q.cx}),
        .wr_idx  (r_q.idx),
        .wr_full (wr_full),
        .rd_tile (r_q.rtile),
        .rd_pos  (r_q.rpos),
        .rd_cnt  (rd_cnt),
        .rd_idx  (rd_idx)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_ACCEPT: begin
                if (in_valid) begin
                    r_d.xlo   = nx_lo;
                    r_d.xhi   = nx_hi;
                    r_d.ylo   = ny_lo;
                    r_d.yhi   = ny_hi;
                    r_d.cx    = nx_lo;
                    r_d.cy    = ny_lo;
                    r_d.idx   = in_idx;
                    r_d.pend  = frame_end;
                    r_d.state = ST_WALK;
                end else if (frame_end) begin
                    r_d.done  = 1'b1;
                    r_d.rtile = '0;
                    r_d.state = ST_HDR;
                end
            end
            ST_WALK: begin
                if (wr_full) r_d.ovf = 1'b1;
                if (r_q.cx == r_q.xhi) begin
                    r_d.cx = r_q.xlo;
                    if (r_q.cy == r_q.yhi) begin
                        if (r_q.pend) begin
                            r_d.pend  = 1'b0;
                            r_d.done  = 1'b1;
                            r_d.rtile = '0;
                            r_d.state = ST_HDR;
                        end else begin
                            r_d.state = ST_ACCEPT;
                        end
                    end else begin
                        r_d.cy = r_q.cy + 1'b1;
                    end
                end else begin
                    r_d.cx = r_q.cx + 1'b1;
                end
            end
            ST_HDR: begin
                if (out_ready) begin
                    r_d.rpos  = '0;
                    r_d.state = (rd_cnt == '0) ? ST_EOT : ST_ENT;
                end
            end
            ST_ENT: begin
                if (out_ready) begin
                    if (CNT_W'(r_q.rpos) + 1'b1 == rd_cnt)
                        r_d.state = ST_EOT;
                    else
                        r_d.rpos = r_q.rpos + 1'b1;
                end
            end
            ST_EOT: begin
                if (out_ready) begin
                    if (r_q.rtile == TN_W'(NT - 1)) begin
                        r_d.done  = 1'b0;
                        r_d.ovf   = 1'b0;
                        r_d.state = ST_ACCEPT;
                    end else begin
                        r_d.rtile = r_q.rtile + 1'b1;
                        r_d.state = ST_HDR;
                    end
                end
            end
            default: r_d.state = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_ACCEPT;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        in_ready  = (r_q.state == ST_ACCEPT);
        out_valid = (r_q.state == ST_HDR) || (r_q.state == ST_ENT) || (r_q.state == ST_EOT);
        out_kind  = (r_q.state == ST_ENT) ? KIND_ENT :
                    (r_q.state == ST_EOT) ? KIND_EOT : KIND_HDR;
        out_tile  = r_q.rtile;
        out_idx   = (r_q.state == ST_ENT) ? rd_idx : '0;
        bin_done  = r_q.done;
        overflow  = r_q.ovf;
    end

    a_r2_range_order: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (nx_lo <= nx_hi) && (ny_lo <= ny_hi));
    a_r4_done_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        bin_done |-> !in_ready);
    a_r5_no_early_readout: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_done |-> !out_valid);
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_kind)
                                      && $stable(out_tile) && $stable(out_idx));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow || (!bin_done && in_ready));
endmodule

// File: tb/tile_binner_tb_top.sv
`timescale 1ns/1ps
module tile_binner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [5:0] in_idx = '0;
    logic [7:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
    logic       frame_end = 1'b0;
    logic       bin_done, overflow, out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_kind;
    logic [3:0] out_tile;
    logic [5:0] out_idx;

    always #2.5 clk = ~clk;

    tile_binner dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .in_x2(in_x2), .in_y2(in_y2), .frame_end(frame_end), .bin_done(bin_done),
        .overflow(overflow), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_tile(out_tile), .out_idx(out_idx)
    );

    typedef struct packed { logic [1:0] kind; logic [3:0] tile; logic [5:0] idx; } item_t;
    item_t expq[$];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    int  ecnt [16];
    int  elist [16][4];
    bit  eovf = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void axis(input int a, input int b, input int c,
                                 output int lo, output int hi);
        int mn, mx;
        mn = a; mx = a;
        if (b < mn) mn = b;
        if (c < mn) mn = c;
        if (b > mx) mx = b;
        if (c > mx) mx = c;
        lo = mn / 16; hi = mx / 16;
        if (lo > 3) lo = 3;
        if (hi > 3) hi = 3;
    endfunction

    task automatic push_frame();
        for (int t = 0; t < 16; t++) begin
            expq.push_back('{kind: 2'd0, tile: 4'(t), idx: 6'd0});
            for (int k = 0; k < ecnt[t]; k++)
                expq.push_back('{kind: 2'd1, tile: 4'(t), idx: 6'(elist[t][k])});
            expq.push_back('{kind: 2'd2, tile: 4'(t), idx: 6'd0});
            ecnt[t] = 0;
        end
    endtask

    task automatic wait_ready();
        while (!in_ready) @(negedge clk);
    endtask

    // Called at a falling edge. Drives one triangle; last=1 closes the frame with it.
    task automatic send_tri(int idx, int x0, int y0, int x1, int y1, int x2, int y2, bit last);
        int xl, xh, yl, yh, n;
        axis(x0, x1, x2, xl, xh);
        axis(y0, y1, y2, yl, yh);
        n = (xh - xl + 1) * (yh - yl + 1);
        for (int ty = yl; ty <= yh; ty++)
            for (int tx = xl; tx <= xh; tx++) begin
                int t = ty * 4 + tx;
                if (ecnt[t] < 4) begin elist[t][ecnt[t]] = idx; ecnt[t]++; end
                else eovf = 1;
            end
        wait_ready();
        in_valid = 1'b1; in_idx = 6'(idx); frame_end = last;
        in_x0 = 8'(x0); in_y0 = 8'(y0); in_x1 = 8'(x1);
        in_y1 = 8'(y1); in_x2 = 8'(x2); in_y2 = 8'(y2);
        if (last) push_frame();
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin in_valid = 1'b0; frame_end = 1'b0; end
            check(!in_ready, "R3 in_ready low during tile walk", int'(in_ready), 0);
            if (last) begin
                check(!bin_done, "R4 bin_done before last write", int'(bin_done), 0);
                check(!out_valid, "R5 no readout while binning", int'(out_valid), 0);
            end
        end
        @(negedge clk);
        if (last) begin
            check(bin_done, "R4 bin_done after last write", int'(bin_done), 1);
            check(!in_ready, "R4 input blocked while done", int'(in_ready), 0);
        end else begin
            check(in_ready, "R3 in_ready back after walk", int'(in_ready), 1);
        end
    endtask

    task automatic finish_frame(bit exp_ovf);
        check(overflow == exp_ovf, "R8 overflow flag in readout", int'(overflow), int'(exp_ovf));
        while (bin_done) @(negedge clk);
        check(expq.size() == 0, "R6 all readout beats seen", expq.size(), 0);
        check(!overflow, "R9 overflow cleared", int'(overflow), 0);
        check(in_ready, "R9 in_ready after readout", int'(in_ready), 1);
        check(!out_valid, "R9 out_valid low after readout", int'(out_valid), 0);
        eovf = 0;
    endtask

    // Monitor: stall pattern plus scoreboard compare of each handshake beat.
    int   mcyc = 0;
    bit   prev_stall = 0;
    item_t prev_beat;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            item_t cur, exp;
            cur = '{kind: out_kind, tile: out_tile, idx: out_idx};
            if (prev_stall) begin
                check(out_valid, "R7 valid held on stall", int'(out_valid), 1);
                check(cur == prev_beat, "R7 beat held on stall", int'(cur), int'(prev_beat));
            end
            mcyc++;
            out_ready = (mcyc % 3) != 2;
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R6 unexpected beat", int'(cur), -1);
                end else begin
                    exp = expq.pop_front();
                    check(cur == exp, (exp.kind == 2'd1) ? "R6 entry beat" :
                          (exp.kind == 2'd0) ? "R6 header beat" : "R10 end beat",
                          int'(cur), int'(exp));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_beat  = cur;
        end
    end

    initial begin
        for (int t = 0; t < 16; t++) ecnt[t] = 0;
        repeat (3) @(negedge clk);
        check(in_ready, "R1 in_ready at reset", int'(in_ready), 1);
        check(!bin_done, "R1 bin_done at reset", int'(bin_done), 0);
        check(!out_valid, "R1 out_valid at reset", int'(out_valid), 0);
        check(!overflow, "R1 overflow at reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Frame 1: single tile, row span, full screen, clamped column (R2, R3).
        send_tri(1, 1, 1, 5, 3, 2, 9, 0);
        send_tri(2, 10, 20, 40, 20, 25, 22, 0);
        send_tri(4, 0, 0, 63, 63, 30, 30, 0);
        send_tri(3, 50, 0, 200, 255, 60, 100, 1);
        finish_frame(0);

        // Frame 2: five triangles in tile 5, fifth dropped (R8).
        for (int i = 0; i < 4; i++) send_tri(10 + i, 20, 20, 21, 25, 30, 30, 0);
        send_tri(14, 20, 20, 21, 25, 30, 30, 1);
        finish_frame(1);

        // Frame 3: frame_end alone, every tile empty (R4, R10).
        wait_ready();
        frame_end = 1'b1;
        push_frame();
        @(posedge clk);
        @(negedge clk);
        frame_end = 1'b0;
        check(bin_done, "R4 bin_done after lone frame_end", int'(bin_done), 1);
        finish_frame(0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule